// File: doc/BRIEF.md
# Frame Buffer Engine Control Register Block

This block is the software-facing register slave that sits in front of a frame buffer engine, whether the engine moves video frames from memory to a stream or from a stream to memory. Software sets the frame geometry (width in pixels, height in lines, line stride in bytes and a color format code) and the base addresses of up to two picture planes. The second plane serves semi-planar layouts, in which the chroma plane sits at its own address. The engine datapath reads all of these values as static configuration outputs.

The control word launches frames. Setting the start bit while the engine is idle sends a one-cycle launch pulse to the datapath. Setting the auto-restart bit makes every reported frame completion launch the next frame at once, which gives continuous streaming. Writing zero ends streaming after the current frame. The control word reads back the idle bit, so a poll that sees exactly the idle pattern knows the engine has stopped. The bus is a simple 32-bit word port: a write takes effect in one cycle, and read data arrives one cycle after the request.

Top module: `fbc_ctrl_regs`

## Requirements
- R1: After reset every configuration output is 0, `frame_start_o` is 0 and the control word (offset 0x00) reads 0x04, meaning only the idle bit (bit 2) is set.
- R2: Writes to offsets 0x10 (width), 0x18 (height), 0x20 (stride), 0x28 (color), 0x30 (plane 0 base) and 0x3C (plane 1 base) are stored, driven on the matching `cfg_*` output and read back. Width, height and stride keep their low 16 bits, color keeps its low 8 bits and the plane bases keep all 32. The unused upper bits read as 0.
- R3: Writes to any other offset change nothing, and reads of any other offset return 0.
- R4: A control write with bit 0 (start) set while idle makes `frame_start_o` high for exactly one cycle, starting at the clock edge that accepts the write. From then on the idle bit reads 0, and the start bit has already cleared because the frame consumed it.
- R5: Single shot: when `frame_done_i` is high while a frame runs, and neither start nor auto-restart is set, the engine returns to idle at that edge with no new launch. The control word then reads exactly 0x04.
- R6: Auto-restart: if bit 7 (auto-restart) is set when `frame_done_i` arrives, `frame_start_o` pulses at that same edge and the block stays busy. Bit 7 stays set.
- R7: A start written while a frame runs stays pending (bit 0 reads 1). It launches the next frame when `frame_done_i` arrives and then clears.
- R8: Writing 0 to the control word clears start and auto-restart. The running frame still ends on `frame_done_i`, and no further frame is launched.
- R9: When a control write and `frame_done_i` fall in the same cycle, the newly written start and auto-restart bits decide whether a new frame launches.
- R10: A read request gives `bus_rd_valid_o` high for exactly the following cycle, with `bus_rd_data_o` holding the data. A read in the same cycle as a write to the same offset returns the old value.
- R11: The idle bit is read-only, so writing bit 2 has no effect. A `frame_done_i` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_en_i | input | 1 | Write request, one word per cycle |
| bus_wr_addr_i | input | ADDR_W | Write byte offset |
| bus_wr_data_i | input | DATA_W | Write data |
| bus_rd_en_i | input | 1 | Read request |
| bus_rd_addr_i | input | ADDR_W | Read byte offset |
| bus_rd_data_o | output | DATA_W | Read data, valid with bus_rd_valid_o |
| bus_rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| frame_start_o | output | 1 | One-cycle frame launch pulse to the datapath |
| frame_done_i | input | 1 | Frame completion from the datapath |
| cfg_width_o | output | DIM_W | Frame width |
| cfg_height_o | output | DIM_W | Frame height |
| cfg_stride_o | output | DIM_W | Line stride |
| cfg_color_o | output | COLOR_W | Color format code |
| cfg_plane0_o | output | PLANE_W | First plane base address |
| cfg_plane1_o | output | PLANE_W | Second plane base address |

## Verification
A control-word write and a frame completion can land in the same cycle. The rule is that the freshly written start and auto-restart bits decide the relaunch. The bench drives both inputs together from one task while the block streams continuously. It writes zero against a completion and expects no pulse and a read of 0x04. It writes auto-restart alone against the completion of a single-shot frame and expects a pulse and a read of 0x80. The cycle reference model scores the same collisions on every clock, as do read-while-write on one offset.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    // Register offsets (byte addresses of 32-bit words)
    localparam int unsigned OFF_CTRL   = 32'h00;
    localparam int unsigned OFF_WIDTH  = 32'h10;
    localparam int unsigned OFF_HEIGHT = 32'h18;
    localparam int unsigned OFF_STRIDE = 32'h20;
    localparam int unsigned OFF_COLOR  = 32'h28;
    localparam int unsigned OFF_PLANE0 = 32'h30;
    localparam int unsigned OFF_PLANE1 = 32'h3C;

    // Control word bit positions
    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_IDLE  = 2;
    localparam int unsigned BIT_AUTO  = 7;

    typedef struct packed {
        logic busy;
        logic start_pend;
        logic auto_rs;
        logic launch;
    } ctrl_state_t;

    function automatic logic is_mapped(input logic [31:0] addr);
        case (addr)
            OFF_CTRL, OFF_WIDTH, OFF_HEIGHT, OFF_STRIDE,
            OFF_COLOR, OFF_PLANE0, OFF_PLANE1: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fbc_reg_file.sv
module fbc_reg_file
    import fbc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int DIM_W      = 16,
    parameter int COLOR_W    = 8,
    parameter int PLANE_W    = 32,
    parameter bit TWO_PLANES = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DIM_W-1:0]   width_o,
    output logic [DIM_W-1:0]   height_o,
    output logic [DIM_W-1:0]   stride_o,
    output logic [COLOR_W-1:0] color_o,
    output logic [PLANE_W-1:0] plane0_o,
    output logic [PLANE_W-1:0] plane1_o
);

    typedef struct packed {
        logic [DIM_W-1:0]   width;
        logic [DIM_W-1:0]   height;
        logic [DIM_W-1:0]   stride;
        logic [COLOR_W-1:0] color;
        logic [PLANE_W-1:0] plane0;
    } geom_t;

    localparam logic [31:0] WADDR_PAD = 32'(0);

    geom_t       geom_d, geom_q;
    logic [31:0] waddr;

    assign waddr = WADDR_PAD | 32'(wr_addr_i);

    always_comb begin
        geom_d = geom_q;
        if (wr_en_i) begin
            case (waddr)
                OFF_WIDTH:  geom_d.width  = wr_data_i[DIM_W-1:0];
                OFF_HEIGHT: geom_d.height = wr_data_i[DIM_W-1:0];
                OFF_STRIDE: geom_d.stride = wr_data_i[DIM_W-1:0];
                OFF_COLOR:  geom_d.color  = wr_data_i[COLOR_W-1:0];
                OFF_PLANE0: geom_d.plane0 = wr_data_i[PLANE_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) geom_q <= '0;
        else         geom_q <= geom_d;
    end

    assign width_o  = geom_q.width;
    assign height_o = geom_q.height;
    assign stride_o = geom_q.stride;
    assign color_o  = geom_q.color;
    assign plane0_o = geom_q.plane0;

    // Second plane register exists only for semi-planar capable builds
    if (TWO_PLANES) begin : g_plane1
        logic [PLANE_W-1:0] p1_d, p1_q;

        always_comb begin
            p1_d = p1_q;
            if (wr_en_i && (waddr == OFF_PLANE1)) p1_d = wr_data_i[PLANE_W-1:0];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) p1_q <= '0;
            else         p1_q <= p1_d;
        end

        assign plane1_o = p1_q;
    end else begin : g_no_plane1
        assign plane1_o = '0;
    end

endmodule

// File: rtl/fbc_ctrl_fsm.sv
module fbc_ctrl_fsm
    import fbc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ctrl_wr_i,
    input  logic wr_start_i,
    input  logic wr_auto_i,
    input  logic frame_done_i,
    output logic busy_o,
    output logic start_pend_o,
    output logic auto_o,
    output logic frame_start_o
);

    ctrl_state_t st_d, st_q;
    logic        start_eff;
    logic        auto_eff;
    logic        launch;

    always_comb begin
        // A control write in this cycle overrides the stored bits
        start_eff = ctrl_wr_i ? wr_start_i : st_q.start_pend;
        auto_eff  = ctrl_wr_i ? wr_auto_i  : st_q.auto_rs;

        if (st_q.busy) launch = frame_done_i && (start_eff || auto_eff);
        else           launch = start_eff;

        st_d.launch     = launch;
        st_d.start_pend = start_eff && !launch;
        st_d.auto_rs    = auto_eff;
        st_d.busy       = launch || (st_q.busy && !frame_done_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o        = st_q.busy;
    assign start_pend_o  = st_q.start_pend;
    assign auto_o        = st_q.auto_rs;
    assign frame_start_o = st_q.launch;

endmodule

// File: rtl/fbc_rd_port.sv
module fbc_rd_port
    import fbc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int DIM_W   = 16,
    parameter int COLOR_W = 8,
    parameter int PLANE_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [DIM_W-1:0]   width_i,
    input  logic [DIM_W-1:0]   height_i,
    input  logic [DIM_W-1:0]   stride_i,
    input  logic [COLOR_W-1:0] color_i,
    input  logic [PLANE_W-1:0] plane0_i,
    input  logic [PLANE_W-1:0] plane1_i,
    input  logic               busy_i,
    input  logic               start_pend_i,
    input  logic               auto_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               rd_valid_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t               rd_d, rd_q;
    logic [DATA_W-1:0] word;
    logic [31:0]       raddr;

    assign raddr = 32'(rd_addr_i);

    always_comb begin
        word = '0;
        case (raddr)
            OFF_CTRL: begin
                word[BIT_START] = start_pend_i;
                word[BIT_IDLE]  = !busy_i;
                word[BIT_AUTO]  = auto_i;
            end
            OFF_WIDTH:  word = DATA_W'(width_i);
            OFF_HEIGHT: word = DATA_W'(height_i);
            OFF_STRIDE: word = DATA_W'(stride_i);
            OFF_COLOR:  word = DATA_W'(color_i);
            OFF_PLANE0: word = DATA_W'(plane0_i);
            OFF_PLANE1: word = DATA_W'(plane1_i);
            default:    word = '0;
        endcase

        rd_d.valid = rd_en_i;
        rd_d.data  = rd_en_i ? word : rd_q.data;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data_o  = rd_q.data;
    assign rd_valid_o = rd_q.valid;

endmodule

// File: rtl/fbc_ctrl_regs.sv
module fbc_ctrl_regs
    import fbc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int DIM_W      = 16,
    parameter int COLOR_W    = 8,
    parameter int PLANE_W    = 32,
    parameter bit TWO_PLANES = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_wr_en_i,
    input  logic [ADDR_W-1:0]  bus_wr_addr_i,
    input  logic [DATA_W-1:0]  bus_wr_data_i,
    input  logic               bus_rd_en_i,
    input  logic [ADDR_W-1:0]  bus_rd_addr_i,
    output logic [DATA_W-1:0]  bus_rd_data_o,
    output logic               bus_rd_valid_o,
    output logic               frame_start_o,
    input  logic               frame_done_i,
    output logic [DIM_W-1:0]   cfg_width_o,
    output logic [DIM_W-1:0]   cfg_height_o,
    output logic [DIM_W-1:0]   cfg_stride_o,
    output logic [COLOR_W-1:0] cfg_color_o,
    output logic [PLANE_W-1:0] cfg_plane0_o,
    output logic [PLANE_W-1:0] cfg_plane1_o
);

    logic ctrl_wr;
    logic busy;
    logic start_pend;
    logic auto_rs;

    assign ctrl_wr = bus_wr_en_i && (32'(bus_wr_addr_i) == OFF_CTRL);

    fbc_reg_file #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W),
        .COLOR_W(COLOR_W), .PLANE_W(PLANE_W), .TWO_PLANES(TWO_PLANES)
    ) i_reg_file (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (bus_wr_en_i),
        .wr_addr_i (bus_wr_addr_i),
        .wr_data_i (bus_wr_data_i),
        .width_o   (cfg_width_o),
        .height_o  (cfg_height_o),
        .stride_o  (cfg_stride_o),
        .color_o   (cfg_color_o),
        .plane0_o  (cfg_plane0_o),
        .plane1_o  (cfg_plane1_o)
    );

    fbc_ctrl_fsm i_ctrl_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ctrl_wr_i     (ctrl_wr),
        .wr_start_i    (bus_wr_data_i[BIT_START]),
        .wr_auto_i     (bus_wr_data_i[BIT_AUTO]),
        .frame_done_i  (frame_done_i),
        .busy_o        (busy),
        .start_pend_o  (start_pend),
        .auto_o        (auto_rs),
        .frame_start_o (frame_start_o)
    );

    fbc_rd_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W),
        .COLOR_W(COLOR_W), .PLANE_W(PLANE_W)
    ) i_rd_port (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rd_en_i      (bus_rd_en_i),
        .rd_addr_i    (bus_rd_addr_i),
        .width_i      (cfg_width_o),
        .height_i     (cfg_height_o),
        .stride_i     (cfg_stride_o),
        .color_i      (cfg_color_o),
        .plane0_i     (cfg_plane0_o),
        .plane1_i     (cfg_plane1_o),
        .busy_i       (busy),
        .start_pend_i (start_pend),
        .auto_i       (auto_rs),
        .rd_data_o    (bus_rd_data_o),
        .rd_valid_o   (bus_rd_valid_o)
    );

endmodule

// File: rtl/fbc_checker.sv
module fbc_checker
    import fbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_i,
    input logic              rd_valid_i,
    input logic              frame_start_i,
    input logic              frame_done_i,
    input logic              busy_i,
    input logic              start_pend_i,
    input logic              auto_i
);

    logic cw;
    assign cw = wr_en_i && (32'(wr_addr_i) == OFF_CTRL);

    assert_launch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cw && wr_data_i[BIT_START] && !busy_i) |=> (frame_start_i && busy_i && !start_pend_i));

    assert_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && frame_done_i && !start_pend_i && !auto_i && !cw) |=> (!busy_i && !frame_start_i));

    assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && frame_done_i && auto_i && !cw) |=> (frame_start_i && busy_i && auto_i));

    assert_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !frame_done_i && !cw) |=> ($stable(start_pend_i) && busy_i && !frame_start_i));

    assert_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cw && !wr_data_i[BIT_START] && !wr_data_i[BIT_AUTO]) |=> (!start_pend_i && !auto_i && !frame_start_i));

    assert_collide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cw && busy_i && frame_done_i && wr_data_i[BIT_AUTO]) |=> frame_start_i);

    assert_rdvalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_i);

    assert_rdquiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_valid_i);

    assert_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !is_mapped(32'(rd_addr_i))) |=> (rd_data_i == '0));

    assert_idle_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && frame_done_i && !cw && !start_pend_i) |=> (!busy_i && !frame_start_i));

endmodule

bind fbc_ctrl_regs fbc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (bus_wr_en_i),
    .wr_addr_i     (bus_wr_addr_i),
    .wr_data_i     (bus_wr_data_i),
    .rd_en_i       (bus_rd_en_i),
    .rd_addr_i     (bus_rd_addr_i),
    .rd_data_i     (bus_rd_data_o),
    .rd_valid_i    (bus_rd_valid_o),
    .frame_start_i (frame_start_o),
    .frame_done_i  (frame_done_i),
    .busy_i        (busy),
    .start_pend_i  (start_pend),
    .auto_i        (auto_rs)
);

// File: tb/test_fbc_ctrl_regs.sv
`timescale 1ns/1ps
module test_fbc_ctrl_regs;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int DIM_W   = 16;
    localparam int COLOR_W = 8;
    localparam int PLANE_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic               rd_en = 1'b0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [DATA_W-1:0]  rd_data;
    logic               rd_valid;
    logic               fstart;
    logic               fdone = 1'b0;
    logic [DIM_W-1:0]   c_w, c_h, c_s;
    logic [COLOR_W-1:0] c_c;
    logic [PLANE_W-1:0] c_p0, c_p1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit ended = 1'b0;

    // reference model state
    bit          m_busy, m_start, m_auto, m_fs, m_rv;
    int unsigned m_rd, m_w, m_h, m_s, m_c, m_p0, m_p1;

    always #10 clk = ~clk;

    fbc_ctrl_regs i_fbc_ctrl_regs (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_wr_en_i(wr_en), .bus_wr_addr_i(wr_addr), .bus_wr_data_i(wr_data),
        .bus_rd_en_i(rd_en), .bus_rd_addr_i(rd_addr),
        .bus_rd_data_o(rd_data), .bus_rd_valid_o(rd_valid),
        .frame_start_o(fstart), .frame_done_i(fdone),
        .cfg_width_o(c_w), .cfg_height_o(c_h), .cfg_stride_o(c_s),
        .cfg_color_o(c_c), .cfg_plane0_o(c_p0), .cfg_plane1_o(c_p1)
    );

    function automatic int unsigned model_read(input int unsigned a);
        case (a)
            'h00: return {24'd0, m_auto, 4'd0, !m_busy, 1'b0, m_start};
            'h10: return m_w;
            'h18: return m_h;
            'h20: return m_s;
            'h28: return m_c;
            'h30: return m_p0;
            'h3C: return m_p1;
            default: return 0;
        endcase
    endfunction

    // behavioural reference, advanced on each rising edge from the inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_start = 0; m_auto = 0; m_fs = 0; m_rv = 0; m_rd = 0;
            m_w = 0; m_h = 0; m_s = 0; m_c = 0; m_p0 = 0; m_p1 = 0;
        end else begin
            bit se, ae, go;
            m_rv = rd_en;
            if (rd_en) m_rd = model_read(rd_addr);
            se = (wr_en && wr_addr == 0) ? wr_data[0] : m_start;
            ae = (wr_en && wr_addr == 0) ? wr_data[7] : m_auto;
            go = m_busy ? (fdone && (se || ae)) : se;
            m_fs = go;
            m_start = se && !go;
            m_auto = ae;
            m_busy = go || (m_busy && !fdone);
            if (wr_en) begin
                case (wr_addr)
                    'h10: m_w = wr_data & 'hFFFF;
                    'h18: m_h = wr_data & 'hFFFF;
                    'h20: m_s = wr_data & 'hFFFF;
                    'h28: m_c = wr_data & 'hFF;
                    'h30: m_p0 = wr_data;
                    'h3C: m_p1 = wr_data;
                    default: ;
                endcase
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (model_on && !ended) begin
            checks++;
            if (fstart !== m_fs || rd_valid !== m_rv || rd_data !== m_rd) begin
                errors++;
                $display("FAIL R4/R10 model: start=%0b valid=%0b data=%h expected start=%0b valid=%0b data=%h",
                         fstart, rd_valid, rd_data, m_fs, m_rv, m_rd);
            end
            checks++;
            if (c_w !== m_w[15:0] || c_h !== m_h[15:0] || c_s !== m_s[15:0] ||
                c_c !== m_c[7:0] || c_p0 !== m_p0 || c_p1 !== m_p1) begin
                errors++;
                $display("FAIL R2 model: cfg=%h/%h/%h/%h/%h/%h expected %h/%h/%h/%h/%h/%h",
                         c_w, c_h, c_s, c_c, c_p0, c_p1, m_w, m_h, m_s, m_c, m_p0, m_p1);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        fdone = 1'b1;
        @(negedge clk);
        fdone = 1'b0;
    endtask

    task automatic collide(input logic [31:0] d);
        @(negedge clk);
        fdone = 1'b1; wr_en = 1'b1; wr_addr = 8'h00; wr_data = d;
        @(negedge clk);
        fdone = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R1 reset state
        chk("R1 frame_start", {31'd0, fstart}, 0);
        bus_read(8'h00, v); chk("R1 ctrl", v, 32'h04);
        bus_read(8'h30, v); chk("R1 plane0", v, 0);
        chk("R1 cfg_width", {16'd0, c_w}, 0);

        // R2 geometry and planes
        bus_write(8'h10, 32'd1920);
        bus_write(8'h18, 32'd1080);
        bus_write(8'h20, 32'h1E00);
        bus_write(8'h28, 32'h0ABC);
        bus_write(8'h30, 32'h1000_0000);
        bus_write(8'h3C, 32'h1020_0000);
        bus_read(8'h10, v); chk("R2 width", v, 32'd1920);
        bus_read(8'h18, v); chk("R2 height", v, 32'd1080);
        bus_read(8'h28, v); chk("R2 color low bits", v, 32'hBC);
        bus_read(8'h3C, v); chk("R2 plane1", v, 32'h1020_0000);
        chk("R2 cfg_stride", {16'd0, c_s}, 32'h1E00);
        chk("R2 cfg_plane0", c_p0, 32'h1000_0000);
        bus_write(8'h20, 32'h1234_5678);
        bus_read(8'h20, v); chk("R2 stride upper bits", v, 32'h5678);

        // R3 reserved offsets
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h31, 32'hDEAD_BEEF);
        bus_write(8'h38, 32'hDEAD_BEEF);
        bus_read(8'h04, v); chk("R3 read 0x04", v, 0);
        bus_read(8'h38, v); chk("R3 read 0x38", v, 0);
        bus_read(8'h30, v); chk("R3 plane0 untouched", v, 32'h1000_0000);
        bus_read(8'h00, v); chk("R3 ctrl untouched", v, 32'h04);

        // R4 / R5 single shot
        bus_write(8'h00, 32'h01);
        chk("R4 launch pulse", {31'd0, fstart}, 1);
        bus_read(8'h00, v); chk("R4 busy, start cleared", v, 32'h00);
        chk("R4 pulse one cycle", {31'd0, fstart}, 0);
        pulse_done();
        chk("R5 no relaunch", {31'd0, fstart}, 0);
        bus_read(8'h00, v); chk("R5 idle poll", v, 32'h04);

        // R7 / R6 / R8 continuous then stop
        bus_write(8'h00, 32'h01);
        chk("R4 launch 2", {31'd0, fstart}, 1);
        bus_write(8'h00, 32'h81);
        bus_read(8'h00, v); chk("R7 start pending", v, 32'h81);
        pulse_done();
        chk("R7 pending launches", {31'd0, fstart}, 1);
        bus_read(8'h00, v); chk("R7 pending consumed", v, 32'h80);
        pulse_done();
        chk("R6 auto relaunch", {31'd0, fstart}, 1);
        bus_read(8'h00, v); chk("R6 still busy", v, 32'h80);
        bus_write(8'h00, 32'h00);
        bus_read(8'h00, v); chk("R8 stop busy", v, 32'h00);
        pulse_done();
        chk("R8 no relaunch", {31'd0, fstart}, 0);
        bus_read(8'h00, v); chk("R8 idle", v, 32'h04);

        // R9 write colliding with done
        bus_write(8'h00, 32'h01);
        bus_write(8'h00, 32'h81);
        pulse_done();
        collide(32'h00);
        chk("R9 stop wins", {31'd0, fstart}, 0);
        bus_read(8'h00, v); chk("R9 idle after stop", v, 32'h04);
        bus_write(8'h00, 32'h01);
        collide(32'h80);
        chk("R9 auto written wins", {31'd0, fstart}, 1);
        bus_read(8'h00, v); chk("R9 streaming", v, 32'h80);
        bus_write(8'h00, 32'h00);
        pulse_done();

        // R11 idle read-only, stray done ignored
        bus_write(8'h00, 32'h04);
        chk("R11 idle bit write", {31'd0, fstart}, 0);
        bus_read(8'h00, v); chk("R11 ctrl", v, 32'h04);
        pulse_done();
        chk("R11 stray done", {31'd0, fstart}, 0);
        bus_read(8'h00, v); chk("R11 still idle", v, 32'h04);
        bus_write(8'h00, 32'h01);
        bus_write(8'h00, 32'h04);
        bus_read(8'h00, v); chk("R11 busy despite bit2", v, 32'h00);
        pulse_done();

        // R10 read latency and read-during-write
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h18; wr_data = 32'd77;
        rd_en = 1'b1; rd_addr = 8'h18;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 valid", {31'd0, rd_valid}, 1);
        chk("R10 old value", rd_data, 32'd1080);
        @(negedge clk);
        chk("R10 valid drops", {31'd0, rd_valid}, 0);
        bus_read(8'h18, v); chk("R10 new value", v, 32'd77);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule